// File: doc/BRIEF.md
# Selectable Prescaler Feeding a Presettable Divide-by-N Stage

This block divides a stream of input events in two stages, all inside one system clock domain. Every input event is a single-cycle enable pulse. The first stage is a prescaler with four fixed ratios, picked by a two-bit code: 4, 16, 64 or 100. It emits a single-cycle pulse when each of its periods completes. The second stage is a 4-bit down counter whose modulus N is taken from a preset bus. It emits a single-cycle terminal pulse once for every N events it counts, and then restarts by itself.

A routing input picks the event source for the second stage. When the input is high, the two stages are chained and the second stage counts prescaler pulses. When it is low, the second stage counts a separate external event input and the prescaler runs on its own. A reload input restarts the second stage's period from the preset bus. A preset of zero is not a valid modulus. While the preset is zero, the block raises an error flag and freezes the second stage instead of dividing.

Top module: `presc_divn`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pre_tick` and `zero_tick` are low. Both stages start at the beginning of a fresh period.
- R2: The prescaler ratio is set by `div_sel` as {F,G}: 2'b00 gives 4, 2'b01 gives 16, 2'b10 gives 64 and 2'b11 gives 100. `pre_tick` is high for exactly one cycle, in the cycle after the `in_tick` that completes a period.
- R3: A change of `div_sel` in the middle of a period does not alter that period. The new ratio applies from the period that begins after the next `pre_tick`.
- R4: The second stage counts down from N = `preset_val`. `zero_tick` is high for one cycle, in the cycle after every Nth counted event. The next period then starts with no further stimulus.
- R5: The boundary moduli work: N = 1 gives a `zero_tick` for every counted event, and N = 15 gives one for every fifteenth event.
- R6: With `cascade` = 1 the second stage counts `pre_tick` pulses and `ext_tick` has no effect. With `cascade` = 0 it counts `ext_tick` pulses and the prescaler's pulses have no effect on it. In both cases the prescaler keeps running.
- R7: A `reload` pulse abandons the current period of the second stage. The following period is N = `preset_val` events long, using the preset value present after the reload.
- R8: When `reload` and a counted event fall in the same cycle, the reload takes effect and the event is discarded. No `zero_tick` follows, and a full N further events are needed.
- R9: While `preset_val` is 0, `n_err` is high and counted events are ignored. No `zero_tick` is produced and the position within the period is kept. Counting resumes from that position once a nonzero preset returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_tick | input | 1 | Event enable counted by the prescaler |
| ext_tick | input | 1 | External event enable for the second stage when not chained |
| cascade | input | 1 | 1: second stage counts prescaler pulses; 0: counts `ext_tick` |
| div_sel | input | 2 | Prescaler ratio code {F,G} |
| preset_val | input | NW (4) | Modulus N of the second stage |
| reload | input | 1 | Restart the second stage period from `preset_val` |
| pre_tick | output | 1 | One-cycle pulse per prescaler period |
| zero_tick | output | 1 | One-cycle terminal pulse per N counted events |
| n_err | output | 1 | High while `preset_val` is zero |

## Verification
Two actions can fall in the same cycle: a `reload` and the counted event that would otherwise finish the second stage's period. The bench first advances the stage to one event before its terminal count. It then raises `reload` and `ext_tick` together in a single cycle. The result is judged correct only if no `zero_tick` follows and exactly N more events are then needed to produce one.

// File: rtl/presc_divn_pkg.sv
package presc_divn_pkg;

   localparam int NUM_CODES = 4;

   typedef enum logic [1:0] {
      SEL_DIV4   = 2'b00,
      SEL_DIV16  = 2'b01,
      SEL_DIV64  = 2'b10,
      SEL_DIV100 = 2'b11
   } div_code_e;

   localparam int DEFAULT_RATIOS [NUM_CODES] = '{4, 16, 64, 100};

   function automatic int max_ratio(input int r [NUM_CODES]);
      int m;
      m = 0;
      for (int i = 0; i < NUM_CODES; i++) begin
         if (r[i] > m) m = r[i];
      end
      return m;
   endfunction

endpackage

// File: rtl/presc_stage.sv
module presc_stage
   import presc_divn_pkg::*;
#(
   parameter int RATIOS [NUM_CODES] = DEFAULT_RATIOS
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_tick,
   input  logic [1:0] div_sel,
   output logic       pre_tick
);

   localparam int MAXR = max_ratio(RATIOS);
   localparam int CW   = $clog2(MAXR + 1);

   for (genvar i = 0; i < NUM_CODES; i++) begin : g_ratio_chk
      if (RATIOS[i] < 2) begin : g_bad
         $error("presc_stage: every ratio must be at least 2");
      end
   end

   logic [CW-1:0] ratio_tab [NUM_CODES];

   for (genvar i = 0; i < NUM_CODES; i++) begin : g_tab
      assign ratio_tab[i] = CW'(RATIOS[i]);
   end

   div_code_e     code;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] act_q;
   logic [CW-1:0] eff;
   logic          at_start;
   logic          last;
   logic          pre_q;

   assign code     = div_code_e'(div_sel);
   assign at_start = (cnt_q == '0);
   // the ratio is sampled only when a period begins
   assign eff      = at_start ? ratio_tab[code] : act_q;
   assign last     = (cnt_q == eff - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= CW'(RATIOS[0]);
         pre_q <= 1'b0;
      end else begin
         pre_q <= in_tick && last;
         if (in_tick) begin
            if (at_start) act_q <= ratio_tab[code];
            cnt_q <= last ? '0 : cnt_q + CW'(1);
         end
      end
   end

   assign pre_tick = pre_q;

endmodule

// File: rtl/tick_route.sv
module tick_route (
   input  logic cascade,
   input  logic pre_tick,
   input  logic ext_tick,
   output logic cnt_tick
);

   always_comb begin
      cnt_tick = cascade ? pre_tick : ext_tick;
   end

endmodule

// File: rtl/divn_stage.sv
module divn_stage #(
   parameter int NW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_tick,
   input  logic          reload,
   input  logic [NW-1:0] preset_val,
   output logic          zero_tick,
   output logic          n_err
);

   if (NW < 1) begin : g_bad_nw
      $error("divn_stage: NW must be at least 1");
   end

   // rem_q == 0 marks a fresh period that takes N from the preset bus
   logic [NW-1:0] rem_q;
   logic [NW-1:0] cur;
   logic          err;
   logic          step;
   logic          hit;
   logic          zero_q;

   assign err  = (preset_val == '0);
   assign cur  = (rem_q == '0) ? preset_val : rem_q;
   assign step = cnt_tick && !reload && !err;
   assign hit  = step && (cur == NW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         zero_q <= 1'b0;
      end else begin
         zero_q <= hit;
         if (reload) begin
            rem_q <= '0;
         end else if (step) begin
            rem_q <= cur - NW'(1);
         end
      end
   end

   assign zero_tick = zero_q;
   assign n_err     = err;

endmodule

// File: rtl/presc_divn.sv
module presc_divn
   import presc_divn_pkg::*;
#(
   parameter int RATIOS [NUM_CODES] = DEFAULT_RATIOS,
   parameter int NW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_tick,
   input  logic          ext_tick,
   input  logic          cascade,
   input  logic [1:0]    div_sel,
   input  logic [NW-1:0] preset_val,
   input  logic          reload,
   output logic          pre_tick,
   output logic          zero_tick,
   output logic          n_err
);

   logic pre_int;
   logic cnt_tick;

   presc_stage #(.RATIOS(RATIOS)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (in_tick),
      .div_sel  (div_sel),
      .pre_tick (pre_int)
   );

   tick_route u_route (
      .cascade  (cascade),
      .pre_tick (pre_int),
      .ext_tick (ext_tick),
      .cnt_tick (cnt_tick)
   );

   divn_stage #(.NW(NW)) u_divn (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_tick   (cnt_tick),
      .reload     (reload),
      .preset_val (preset_val),
      .zero_tick  (zero_tick),
      .n_err      (n_err)
   );

   assign pre_tick = pre_int;

endmodule

// File: rtl/presc_divn_chk.sv
module presc_divn_chk #(
   parameter int NW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_tick,
   input logic          ext_tick,
   input logic          cascade,
   input logic [NW-1:0] preset_val,
   input logic          reload,
   input logic          pre_tick,
   input logic          zero_tick,
   input logic          n_err
);

   // R2
   pre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick |=> !pre_tick);

   // R2
   pre_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick |-> $past(in_tick));

   // R6
   route_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade && !ext_tick) |=> !zero_tick);

   // R6
   route_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade && !pre_tick) |=> !zero_tick);

   // R8
   reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> !zero_tick);

   // R9
   bad_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (preset_val == '0) |=> !zero_tick);

   // R9
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      n_err |=> !zero_tick);

endmodule

bind presc_divn presc_divn_chk #(.NW(NW)) u_chk (.*);

// File: tb/presc_divn_test.sv
module presc_divn_test;

   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_tick = 1'b0;
   logic          ext_tick = 1'b0;
   logic          cascade = 1'b0;
   logic [1:0]    div_sel = 2'b00;
   logic [NW-1:0] preset_val = 4'd5;
   logic          reload = 1'b0;
   logic          pre_tick;
   logic          zero_tick;
   logic          n_err;

   int total = 0;
   int bad   = 0;
   int pre_cnt  = 0;
   int zero_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   presc_divn #(.NW(NW)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_tick    (in_tick),
      .ext_tick   (ext_tick),
      .cascade    (cascade),
      .div_sel    (div_sel),
      .preset_val (preset_val),
      .reload     (reload),
      .pre_tick   (pre_tick),
      .zero_tick  (zero_tick),
      .n_err      (n_err)
   );

   // pulse monitor, sampled 1 ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (pre_tick)  pre_cnt++;
         if (zero_tick) zero_cnt++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic in_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) in_tick = 1'b1;
         @(negedge clk) in_tick = 1'b0;
      end
      settle();
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ext_tick = 1'b1;
         @(negedge clk) ext_tick = 1'b0;
      end
      settle();
   endtask

   task automatic do_reload();
      @(negedge clk) reload = 1'b1;
      @(negedge clk) reload = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 pre_tick in reset", int'(pre_tick), 0);
      check("R1 zero_tick in reset", int'(zero_tick), 0);
      check("R1 n_err with preset 5", int'(n_err), 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1 pre_tick after reset", int'(pre_tick), 0);
      check("R1 zero_tick after reset", int'(zero_tick), 0);
   endtask

   task automatic t_ratios();
      int ratio [4] = '{4, 16, 64, 100};
      int b;
      cascade = 1'b0;
      for (int c = 0; c < 4; c++) begin
         div_sel = 2'(c);
         b = pre_cnt;
         in_pulses(ratio[c] - 1);
         check($sformatf("R2 code %0d before terminal", c), pre_cnt - b, 0);
         in_pulses(1);
         check($sformatf("R2 code %0d at terminal", c), pre_cnt - b, 1);
      end
      // pulse timing and width for ratio 4
      div_sel = 2'b00;
      in_pulses(3);
      @(negedge clk) in_tick = 1'b1;
      @(negedge clk) in_tick = 1'b0;
      check("R2 pre_tick cycle after terminal event", int'(pre_tick), 1);
      @(negedge clk);
      check("R2 pre_tick one cycle wide", int'(pre_tick), 0);
      settle();
   endtask

   task automatic t_sel_change();
      int b;
      div_sel = 2'b00;
      b = pre_cnt;
      in_pulses(2);
      div_sel = 2'b01;
      in_pulses(1);
      check("R3 old ratio kept mid period", pre_cnt - b, 0);
      in_pulses(1);
      check("R3 period ends at old ratio 4", pre_cnt - b, 1);
      in_pulses(15);
      check("R3 new ratio 16 not yet done", pre_cnt - b, 1);
      in_pulses(1);
      check("R3 new ratio 16 completes", pre_cnt - b, 2);
      div_sel = 2'b00;
   endtask

   task automatic t_divn();
      int b;
      int bp;
      cascade = 1'b0;
      preset_val = 4'd5;
      do_reload();
      b = zero_cnt;
      ext_pulses(4);
      check("R4 no zero before N=5", zero_cnt - b, 0);
      ext_pulses(1);
      check("R4 zero at 5th event", zero_cnt - b, 1);
      ext_pulses(10);
      check("R4 auto restart, two more periods", zero_cnt - b, 3);
      b = zero_cnt;
      bp = pre_cnt;
      in_pulses(8);
      check("R6 prescaler runs when not chained", pre_cnt - bp, 2);
      check("R6 prescaler pulses ignored when not chained", zero_cnt - b, 0);
   endtask

   task automatic t_edges();
      int b;
      preset_val = 4'd1;
      do_reload();
      b = zero_cnt;
      ext_pulses(3);
      check("R5 N=1 zero on every event", zero_cnt - b, 3);
      preset_val = 4'd15;
      do_reload();
      b = zero_cnt;
      ext_pulses(14);
      check("R5 N=15 no zero at 14", zero_cnt - b, 0);
      ext_pulses(1);
      check("R5 N=15 zero at 15", zero_cnt - b, 1);
   endtask

   task automatic t_cascade();
      int b;
      int bp;
      cascade = 1'b1;
      div_sel = 2'b00;
      preset_val = 4'd3;
      do_reload();
      b = zero_cnt;
      ext_pulses(5);
      check("R6 ext_tick ignored when chained", zero_cnt - b, 0);
      bp = pre_cnt;
      in_pulses(11);
      check("R6 chained prescaler pulses", pre_cnt - bp, 2);
      check("R6 chained no zero after 2 prescaler pulses", zero_cnt - b, 0);
      in_pulses(1);
      check("R6 chained zero after 3 prescaler pulses", zero_cnt - b, 1);
      cascade = 1'b0;
   endtask

   task automatic t_reload();
      int b;
      preset_val = 4'd6;
      do_reload();
      b = zero_cnt;
      ext_pulses(4);
      preset_val = 4'd3;
      do_reload();
      ext_pulses(2);
      check("R7 reload restarts with new preset", zero_cnt - b, 0);
      ext_pulses(1);
      check("R7 zero after 3 events past reload", zero_cnt - b, 1);
   endtask

   task automatic t_collide();
      int b;
      preset_val = 4'd3;
      do_reload();
      b = zero_cnt;
      ext_pulses(2);
      @(negedge clk) begin
         reload = 1'b1;
         ext_tick = 1'b1;
      end
      @(negedge clk) begin
         reload = 1'b0;
         ext_tick = 1'b0;
      end
      settle();
      check("R8 event dropped under reload", zero_cnt - b, 0);
      ext_pulses(2);
      check("R8 full period needed after reload", zero_cnt - b, 0);
      ext_pulses(1);
      check("R8 zero after N events", zero_cnt - b, 1);
   endtask

   task automatic t_zero_n();
      int b;
      preset_val = 4'd4;
      do_reload();
      b = zero_cnt;
      ext_pulses(2);
      preset_val = 4'd0;
      @(negedge clk);
      check("R9 n_err with preset 0", int'(n_err), 1);
      ext_pulses(5);
      check("R9 events ignored with preset 0", zero_cnt - b, 0);
      preset_val = 4'd4;
      @(negedge clk);
      check("R9 n_err clears", int'(n_err), 0);
      ext_pulses(1);
      check("R9 position held, not yet terminal", zero_cnt - b, 0);
      ext_pulses(1);
      check("R9 resumes from held position", zero_cnt - b, 1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_ratios();
      t_sel_change();
      t_divn();
      t_edges();
      t_cascade();
      t_reload();
      t_collide();
      t_zero_n();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule